// File: doc/BRIEF.md
# Segment-Linking Waveform Sequencer

This block steps through a programmed list of playback stages and turns each stage into a run of sample-memory read addresses, one per sample clock. A stage names a stored buffer, how many samples to read from it, how many times to repeat that read, and a sample position at which a one-clock marker pulse is raised. A small register table gives, for every buffer number, its base address in sample memory and its stored length. The stage list is kept in an append-only store that playback can rewind, so the same list serves every trigger mode.

The host writes the buffer table and appends stages, selects a mode and pulses the trigger input. The block then drives `rd_addr` with `rd_en` high for every sample to be read. The marker comes one clock after the matching address, so it lines up with the read data of a memory that has one clock of latency. A halt input ends playback in any mode.

Top module: `wave_seq`

## Requirements
- R1: Each append stores one stage word (buffer number, sample count, loop count, marker position). `stg_full` rises once DEPTH stages (default 290) are stored, and appends made while it is high are dropped. Reset empties the list.
- R2: During a stage, the addresses issued are base, base+1, ... base+N-1, where base comes from the table entry of the stage's buffer and N is the stage's sample count. A count below the stored length plays only the leading part of the buffer.
- R3: A sample count of zero plays the full stored length of the named buffer, as held in the table.
- R4: A sample count larger than the stored length keeps incrementing the address past the buffer's end, into whatever buffer is stored next in memory.
- R5: A stage with loop count L (16 bits) repeats its address run L times. A loop count of zero plays the run once.
- R6: `marker` is high for exactly the clock after the address at position M of each run (M being the stage's marker position), on every repetition. A position at or beyond the sample count gives no marker.
- R7: Mode 0 (single): a trigger plays the whole list once. `done` then goes high and no further reads are issued.
- R8: Mode 1 (continuous): after the last stage, playback wraps to the first stage and goes on until halted.
- R9: Mode 2 (stepped): each trigger plays exactly one stage, including all its loops, and then no reads are issued until the next trigger. `done` rises after the last stage.
- R10: Mode 3 (burst): the current stage's run repeats, with its loop count ignored, until a trigger has been seen. The run in progress is then completed before the next stage starts. The list wraps after the last stage.
- R11: A halt pulse drops `rd_en` on the next clock, from any state, and clears `done`.
- R12: After reset, `rd_en`, `marker`, `done` and `stg_full` are low. A trigger given while the list is empty starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_we | input | 1 | Append one stage to the list |
| stg_buf | input | BUF_W | Buffer number of the stage |
| stg_cnt | input | ADDR_W | Sample count of the stage (0 = stored length) |
| stg_loops | input | LOOP_W | Repetitions of the stage (0 = once) |
| stg_mark | input | ADDR_W | Marker sample position within a run |
| stg_full | output | 1 | Stage list holds DEPTH entries |
| tbl_we | input | 1 | Write one buffer-table entry |
| tbl_sel | input | BUF_W | Buffer number of the table write |
| tbl_base | input | ADDR_W | Base address of the buffer |
| tbl_len | input | ADDR_W | Stored length of the buffer |
| mode | input | 2 | 0 single, 1 continuous, 2 stepped, 3 burst (sampled at start) |
| trig | input | 1 | Trigger pulse |
| halt | input | 1 | Stop playback |
| rd_addr | output | ADDR_W | Sample-memory read address |
| rd_en | output | 1 | Read address valid |
| marker | output | 1 | Marker pulse, aligned with read data |
| done | output | 1 | List finished in single or stepped mode |

## Verification
Two pairs of events can fall in the same cycle. The first is the marker and the address wrap at the end of a run: a stage whose marker sits on its last sample, with several loops, makes the pulse land exactly when the address jumps back to base. The bench requires one pulse per repetition, each carrying the read data of the last address. The second is a burst trigger and the run end: the trigger is given midway through the third run of the burst stage. The expected stream then holds exactly three full runs before the next stage begins, and every issued address is compared with an arithmetically built sequence.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_STEP   = 2'd2,
    MODE_BURST  = 2'd3
  } play_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PLAY,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/stage_list.sv
module stage_list #(
  parameter int DEPTH = 290,
  parameter int W     = 62,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [W-1:0]     wdata,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] count_q;

  assign full  = (count_q == CNT_W'(DEPTH));
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (we && !full) mem[count_q] <= wdata;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)              count_q <= '0;
    else if (we && !full) count_q <= count_q + 1'b1;
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    (we && full) |=> $stable(count_q));
endmodule

// File: rtl/buf_table.sv
module buf_table #(
  parameter int BUF_W  = 4,
  parameter int ADDR_W = 21,
  localparam int NBUF  = 1 << BUF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BUF_W-1:0]  wsel,
  input  logic [ADDR_W-1:0] wbase,
  input  logic [ADDR_W-1:0] wlen,
  input  logic [BUF_W-1:0]  rsel,
  output logic [ADDR_W-1:0] rbase,
  output logic [ADDR_W-1:0] rlen
);
  logic [ADDR_W-1:0] base_q [NBUF];
  logic [ADDR_W-1:0] len_q  [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (we && wsel == BUF_W'(g)) begin
        base_q[g] <= wbase;
        len_q[g]  <= wlen;
      end
    end
  end

  assign rbase = base_q[rsel];
  assign rlen  = len_q[rsel];
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_seq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int LOOP_W = 16,
  parameter int BUF_W  = 4,
  parameter int DEPTH  = 290
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stg_we,
  input  logic [BUF_W-1:0]  stg_buf,
  input  logic [ADDR_W-1:0] stg_cnt,
  input  logic [LOOP_W-1:0] stg_loops,
  input  logic [ADDR_W-1:0] stg_mark,
  output logic              stg_full,
  input  logic              tbl_we,
  input  logic [BUF_W-1:0]  tbl_sel,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_len,
  input  logic [1:0]        mode,
  input  logic              trig,
  input  logic              halt,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  output logic              marker,
  output logic              done
);
  localparam int STG_W = BUF_W + 2 * ADDR_W + LOOP_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  seq_state_e        state_q;
  play_mode_e        mode_q;
  logic [CNT_W-1:0]  idx_q, list_cnt;
  logic [STG_W-1:0]  rd_word;
  logic [ADDR_W-1:0] base_q, eff_q, mk_q, pos_q, addr_q;
  logic [LOOP_W-1:0] loops_q;
  logic              rd_en_q, marker_q, done_q, tpend_q;

  stage_list #(.DEPTH(DEPTH), .W(STG_W)) u_list (
    .clk(clk), .rst(rst), .we(stg_we),
    .wdata({stg_buf, stg_cnt, stg_loops, stg_mark}),
    .rd_idx(idx_q), .rd_data(rd_word), .count(list_cnt), .full(stg_full)
  );

  logic [BUF_W-1:0]  r_buf;
  logic [ADDR_W-1:0] r_cnt, r_mark, t_base, t_len;
  logic [LOOP_W-1:0] r_loops;
  assign r_buf   = rd_word[STG_W-1 -: BUF_W];
  assign r_cnt   = rd_word[2*ADDR_W+LOOP_W-1 -: ADDR_W];
  assign r_loops = rd_word[ADDR_W+LOOP_W-1 -: LOOP_W];
  assign r_mark  = rd_word[ADDR_W-1:0];

  buf_table #(.BUF_W(BUF_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .wsel(tbl_sel),
    .wbase(tbl_base), .wlen(tbl_len),
    .rsel(r_buf), .rbase(t_base), .rlen(t_len)
  );

  logic iter_end, last, again;
  assign iter_end = (pos_q == eff_q - 1'b1);
  assign last     = (idx_q == list_cnt - 1'b1);
  assign again    = (mode_q == MODE_BURST) ? !(tpend_q || trig) : (loops_q > 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_ONCE;
      idx_q    <= '0;
      base_q   <= '0;
      eff_q    <= '0;
      mk_q     <= '0;
      pos_q    <= '0;
      addr_q   <= '0;
      loops_q  <= '0;
      rd_en_q  <= 1'b0;
      marker_q <= 1'b0;
      done_q   <= 1'b0;
      tpend_q  <= 1'b0;
    end else begin
      marker_q <= (state_q == ST_PLAY) && (pos_q == mk_q);
      if (halt) begin
        state_q <= ST_IDLE;
        rd_en_q <= 1'b0;
        done_q  <= 1'b0;
        tpend_q <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: if (trig && list_cnt != '0) begin
            idx_q   <= '0;
            mode_q  <= play_mode_e'(mode);
            done_q  <= 1'b0;
            state_q <= ST_FETCH;
          end
          ST_FETCH: state_q <= ST_SETUP;
          ST_SETUP: begin
            base_q  <= t_base;
            addr_q  <= t_base;
            eff_q   <= (r_cnt != '0) ? r_cnt : ((t_len != '0) ? t_len : ADDR_W'(1));
            loops_q <= (r_loops != '0) ? r_loops : LOOP_W'(1);
            mk_q    <= r_mark;
            pos_q   <= '0;
            rd_en_q <= 1'b1;
            state_q <= ST_PLAY;
          end
          ST_PLAY: begin
            if (mode_q == MODE_BURST && trig) tpend_q <= 1'b1;
            if (!iter_end) begin
              pos_q  <= pos_q + 1'b1;
              addr_q <= addr_q + 1'b1;
            end else if (again) begin
              pos_q  <= '0;
              addr_q <= base_q;
              if (mode_q != MODE_BURST) loops_q <= loops_q - 1'b1;
            end else begin
              rd_en_q <= 1'b0;
              tpend_q <= 1'b0;
              if (last && (mode_q == MODE_ONCE || mode_q == MODE_STEP)) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                idx_q   <= last ? '0 : idx_q + 1'b1;
                state_q <= (mode_q == MODE_STEP) ? ST_WAIT : ST_FETCH;
              end
            end
          end
          ST_WAIT: if (trig) state_q <= ST_FETCH;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_addr = addr_q;
  assign rd_en   = rd_en_q;
  assign marker  = marker_q;
  assign done    = done_q;

  assert_marker_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    marker |-> $past(rd_en));
  assert_halt_stops_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> !rd_en);
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_en);
  assert_empty_start_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && list_cnt == '0) |=> state_q == ST_IDLE);
endmodule

// File: tb/wave_seq_tb.sv
module wave_seq_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic        stg_we = 0, stg_full, tbl_we = 0, trig = 0, halt = 0;
  logic [3:0]  stg_buf = 0, tbl_sel = 0;
  logic [20:0] stg_cnt = 0, stg_mark = 0, tbl_base = 0, tbl_len = 0, rd_addr;
  logic [15:0] stg_loops = 0;
  logic [1:0]  mode = 0;
  logic        rd_en, marker, done;

  wave_seq dut_i (.*);

  logic [20:0] ram_q = '0;
  always @(posedge clk) if (rd_en) ram_q <= rd_addr ^ 21'h0A5A5;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int tb_base[4] = '{100, 200, 300, 108};
  int tb_len[4]  = '{8, 5, 6, 4};
  int sb[300], sc[300], sl[300], sm[300];
  int nst = 0;
  int exp_a[2048];
  bit exp_k[2048];
  int exp_n = 0, obs_n = 0;
  bit mon_on = 0, prev_v = 0, prev_m = 0;
  logic [20:0] prev_addr = '0;
  string cur_req = "R2";

  always @(negedge clk) if (mon_on) begin
    bit em;
    em = prev_v ? prev_m : 1'b0;
    chk(marker == em, "R6", marker, em);
    if (marker) chk(ram_q == (prev_addr ^ 21'h0A5A5), "R6", ram_q, prev_addr ^ 21'h0A5A5);
    prev_m = 1'b0;
    if (rd_en) begin
      if (obs_n < exp_n) begin
        chk(rd_addr == 21'(exp_a[obs_n]), cur_req, rd_addr, exp_a[obs_n]);
        prev_m = exp_k[obs_n];
      end else chk(1'b0, cur_req, obs_n, exp_n);
      obs_n++;
    end
    prev_v = rd_en;
    prev_addr = rd_addr;
  end

  function automatic int eff_of(input int s);
    return (sc[s] != 0) ? sc[s] : tb_len[sb[s]];
  endfunction

  task automatic push_iter(input int s);
    for (int p = 0; p < eff_of(s); p++) begin
      exp_a[exp_n] = tb_base[sb[s]] + p;
      exp_k[exp_n] = (p == sm[s]);
      exp_n++;
    end
  endtask

  task automatic push_stage(input int s);
    int l;
    l = (sl[s] == 0) ? 1 : sl[s];
    for (int i = 0; i < l; i++) push_iter(s);
  endtask

  task automatic do_reset();
    mon_on = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    nst = 0; exp_n = 0; obs_n = 0; prev_v = 0; prev_m = 0;
    mon_on = 1;
  endtask

  task automatic load_table();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_sel = 4'(i); tbl_base = 21'(tb_base[i]); tbl_len = 21'(tb_len[i]);
    end
    @(negedge clk) tbl_we = 0;
  endtask

  task automatic add_stage(input int b, input int c, input int l, input int m);
    @(negedge clk);
    stg_we = 1; stg_buf = 4'(b); stg_cnt = 21'(c); stg_loops = 16'(l); stg_mark = 21'(m);
    sb[nst] = b; sc[nst] = c; sl[nst] = l; sm[nst] = m; nst++;
    @(negedge clk) stg_we = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(negedge clk) sig = 0;
  endtask

  task automatic wait_obs(input int n, input string req);
    int t = 0;
    while (obs_n < n && t < 5000) begin @(negedge clk); t++; end
    chk(obs_n >= n, req, obs_n, n);
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_sim();
  end

  initial begin
    // R12: reset state and trigger on an empty list
    do_reset();
    chk(rd_en == 0, "R12", rd_en, 0);
    chk(marker == 0, "R12", marker, 0);
    chk(done == 0, "R12", done, 0);
    chk(stg_full == 0, "R12", stg_full, 0);
    cur_req = "R12";
    pulse(trig);
    repeat (10) @(negedge clk);
    chk(obs_n == 0, "R12", obs_n, 0);
    chk(done == 0, "R12", done, 0);

    // R7 single mode; R2 partial, R3 zero count, R4 run-past, R5 loops, R6 markers
    do_reset(); load_table();
    add_stage(0, 5, 2, 4);
    add_stage(1, 0, 1, 2);
    add_stage(0, 11, 1, 9);
    add_stage(2, 4, 0, 7);
    for (int s = 0; s < nst; s++) push_stage(s);
    chk(exp_n == 30, "R5", exp_n, 30);
    cur_req = "R2_R3_R4_R7";
    mode = 2'd0;
    pulse(trig);
    wait_obs(30, "R7");
    repeat (20) @(negedge clk);
    chk(obs_n == 30, "R7", obs_n, 30);
    chk(done == 1, "R7", done, 1);
    chk(rd_en == 0, "R7", rd_en, 0);

    // R9 stepped mode
    do_reset(); load_table();
    add_stage(0, 3, 2, 1);
    add_stage(2, 0, 1, 5);
    add_stage(1, 0, 0, 0);
    for (int s = 0; s < nst; s++) push_stage(s);
    cur_req = "R9";
    mode = 2'd2;
    pulse(trig);
    wait_obs(6, "R9");
    repeat (15) @(negedge clk);
    chk(obs_n == 6, "R9", obs_n, 6);
    chk(done == 0, "R9", done, 0);
    pulse(trig);
    wait_obs(12, "R9");
    repeat (15) @(negedge clk);
    chk(obs_n == 12, "R9", obs_n, 12);
    pulse(trig);
    wait_obs(17, "R9");
    repeat (15) @(negedge clk);
    chk(obs_n == 17, "R9", obs_n, 17);
    chk(done == 1, "R9", done, 1);

    // R8 continuous mode, ended by R11 halt
    do_reset(); load_table();
    add_stage(1, 3, 1, 0);
    add_stage(3, 0, 2, 3);
    for (int k = 0; k < 3; k++) for (int s = 0; s < nst; s++) push_stage(s);
    cur_req = "R8";
    mode = 2'd1;
    pulse(trig);
    wait_obs(25, "R8");
    @(negedge clk) halt = 1;
    @(negedge clk) halt = 0;
    chk(rd_en == 0, "R11", rd_en, 0);
    repeat (10) @(negedge clk);
    chk(rd_en == 0, "R11", rd_en, 0);
    chk(obs_n <= 33, "R8", obs_n, 33);
    chk(done == 0, "R11", done, 0);

    // R10 burst mode: trigger midway through the third run
    do_reset(); load_table();
    add_stage(2, 6, 1, 5);
    add_stage(0, 4, 5, 1);
    for (int i = 0; i < 3; i++) push_iter(0);
    for (int i = 0; i < 12; i++) push_iter(1);
    cur_req = "R10";
    mode = 2'd3;
    pulse(trig);
    wait_obs(14, "R10");
    pulse(trig);
    wait_obs(34, "R10");
    @(negedge clk) halt = 1;
    @(negedge clk) halt = 0;
    chk(rd_en == 0, "R11", rd_en, 0);

    // R1 list capacity
    do_reset();
    for (int i = 0; i < 289; i++) add_stage(0, 1, 1, 0);
    chk(stg_full == 0, "R1", stg_full, 0);
    add_stage(0, 1, 1, 0);
    chk(stg_full == 1, "R1", stg_full, 1);
    add_stage(0, 1, 1, 0);
    chk(stg_full == 1, "R1", stg_full, 1);

    finish_sim();
  end
endmodule